// File: doc/BRIEF.md
# Control Word Forwarding Gate

This block sits where a bus packet carried inside a network frame is about to be released onto the serial bus. It looks at the 16-bit control word the host places in front of each tunnelled packet and makes one decision per packet: send it onto the bus, keep it for the receiving board alone, or throw it away. The upper byte of the word carries control flags. The lower byte carries the bus generation number as the host last saw it.

With each packet-valid strobe the block samples the control word, a broadcast indicator from the parser, the live local bus generation and the bus-reset indication. On the next cycle it raises exactly one of three decision pulses. It also updates a status byte and a saturating packet-error count, which the response trailer reports back to the host. The status stays as it is until the next packet arrives.

A packet is dropped when a reserved flag bit is set, when the bus is in reset, or when the host's generation differs from the local one. The no-forward flag only matters for broadcasts. It confines such a packet to the receiving board.

Top module: `fwd_gate`

## Requirements
- R1: After reset the three decision pulses are low, the status byte is 0x00 and the error count is 0.
- R2: In the cycle after each cycle with `pkt_valid` high, exactly one of `fwd_pulse`, `local_pulse`, `drop_pulse` is high. In a cycle that does not follow a valid cycle, all three are low.
- R3: A packet with `ctrl_word[15:9]` zero, `bus_reset` low and `ctrl_word[7:0]` equal to `local_gen` raises `fwd_pulse`, unless R4 applies.
- R4: A packet that would be forwarded, has `is_bcast` high and has the no-forward flag `ctrl_word[8]` set raises `local_pulse` instead.
- R5: The no-forward flag has no effect on a packet with `is_bcast` low; such a packet is forwarded.
- R6: A packet that arrives while `bus_reset` is high raises `drop_pulse`. The status byte then has bit 0 (bus reset) and bit 1 (dropped) set.
- R7: A packet whose `ctrl_word[7:0]` differs from `local_gen` raises `drop_pulse` and sets status bit 1.
- R8: A packet with any of `ctrl_word[15:9]` nonzero raises `drop_pulse` and sets status bits 3 (packet error) and 1. It also adds one to `err_count`, which stops at 255.
- R9: The status byte and `err_count` change only in the cycle after a valid packet. Status bits 7:4 and bit 2 are always zero.
- R10: `local_gen` and `bus_reset` are sampled only in the `pkt_valid` cycle. Changes to them at any other time leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One-cycle strobe: control word and qualifiers are valid |
| ctrl_word | input | 16 | Flags in [15:8], host bus generation in [7:0] |
| is_bcast | input | 1 | Packet is addressed to all nodes |
| local_gen | input | 8 | Live bus generation number of this board |
| bus_reset | input | 1 | Serial bus reset in progress |
| fwd_pulse | output | 1 | Packet goes onto the bus |
| local_pulse | output | 1 | Packet is handled by this board only |
| drop_pulse | output | 1 | Packet is discarded |
| status | output | 8 | Trailer status: bit3 packet error, bit1 dropped, bit0 bus reset |
| err_count | output | 8 | Saturating count of packets with reserved flag bits set |

## Verification
On every cycle the assertions check three things: the decision pulses are one-hot, there is exactly one pulse after each strobe, and the status stays stable between packets. They also check that a bus reset forces a drop, that a drop always shows in the status, and that a reserved-bit error adds exactly one to the count below saturation. Other behaviours can only be seen in the bench's scenarios. These are the choice between forward and local-only for each combination of broadcast and no-forward, generation mismatches on their own, counter saturation at 255, and the fact that a generation change away from the strobe leaves the latched decision unchanged.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

    localparam int GEN_W     = 8;
    localparam int FLAG_W    = 8;
    localparam int CW_W      = FLAG_W + GEN_W;
    localparam int NOFWD_BIT = 0;
    localparam int STAT_W    = 8;

    typedef enum logic [1:0] {
        V_NONE  = 2'd0,
        V_FWD   = 2'd1,
        V_LOCAL = 2'd2,
        V_DROP  = 2'd3
    } verdict_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [GEN_W-1:0]  gen;
    } ctrl_word_t;

    typedef struct packed {
        logic [3:0] zero_hi;
        logic       pkt_err;
        logic       int_err;
        logic       dropped;
        logic       bus_rst;
    } status_t;

    function automatic logic [FLAG_W-1:0] rsv_mask();
        logic [FLAG_W-1:0] m;
        m = '1;
        m[NOFWD_BIT] = 1'b0;
        return m;
    endfunction

    function automatic verdict_e decide(input logic rsv_err,
                                        input logic bus_rst,
                                        input logic gen_ok,
                                        input logic no_fwd,
                                        input logic bcast);
        if (rsv_err || bus_rst || !gen_ok)
            return V_DROP;
        else if (no_fwd && bcast)
            return V_LOCAL;
        else
            return V_FWD;
    endfunction

    function automatic status_t make_status(input verdict_e v,
                                            input logic rsv_err,
                                            input logic bus_rst);
        status_t s;
        s         = '0;
        s.pkt_err = rsv_err;
        s.dropped = (v == V_DROP);
        s.bus_rst = bus_rst;
        return s;
    endfunction

endpackage

// File: rtl/fgate_decode.sv
module fgate_decode
    import fgate_pkg::*;
(
    input  ctrl_word_t       word,
    output logic             rsv_err,
    output logic             no_fwd,
    output logic [GEN_W-1:0] host_gen
);
    logic [FLAG_W-1:0] rsv_bits;

    always_comb begin
        rsv_bits = word.flags & rsv_mask();
        rsv_err  = |rsv_bits;
        no_fwd   = word.flags[NOFWD_BIT];
        host_gen = word.gen;
    end
endmodule

// File: rtl/fgate_gen_check.sv
module fgate_gen_check
    import fgate_pkg::*;
(
    input  logic [GEN_W-1:0] host_gen,
    input  logic [GEN_W-1:0] local_gen,
    output logic             gen_ok
);
    always_comb gen_ok = (host_gen == local_gen);
endmodule

// File: rtl/fgate_err_counter.sv
module fgate_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fwd_gate.sv
module fwd_gate
    import fgate_pkg::*;
#(
    parameter int ERR_CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pkt_valid,
    input  logic [CW_W-1:0]      ctrl_word,
    input  logic                 is_bcast,
    input  logic [GEN_W-1:0]     local_gen,
    input  logic                 bus_reset,
    output logic                 fwd_pulse,
    output logic                 local_pulse,
    output logic                 drop_pulse,
    output logic [STAT_W-1:0]    status,
    output logic [ERR_CNT_W-1:0] err_count
);
    ctrl_word_t       word;
    logic             rsv_err;
    logic             no_fwd;
    logic [GEN_W-1:0] host_gen;
    logic             gen_ok;
    verdict_e         v_now;
    verdict_e         v_q;
    status_t          stat_q;

    assign word = ctrl_word_t'(ctrl_word);

    fgate_decode u_dec (
        .word     (word),
        .rsv_err  (rsv_err),
        .no_fwd   (no_fwd),
        .host_gen (host_gen)
    );

    fgate_gen_check u_gen (
        .host_gen  (host_gen),
        .local_gen (local_gen),
        .gen_ok    (gen_ok)
    );

    fgate_err_counter #(.W(ERR_CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .inc (pkt_valid && rsv_err),
        .cnt (err_count)
    );

    always_comb v_now = decide(rsv_err, bus_reset, gen_ok, no_fwd, is_bcast);

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= V_NONE;
            stat_q <= '0;
        end else if (pkt_valid) begin
            v_q    <= v_now;
            stat_q <= make_status(v_now, rsv_err, bus_reset);
        end else begin
            v_q    <= V_NONE;
        end
    end

    always_comb begin
        fwd_pulse   = (v_q == V_FWD);
        local_pulse = (v_q == V_LOCAL);
        drop_pulse  = (v_q == V_DROP);
        status      = stat_q;
    end
endmodule

// File: rtl/fgate_chk.sv
module fgate_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          pkt_valid,
    input logic [15:0]   ctrl_word,
    input logic          bus_reset,
    input logic          fwd_pulse,
    input logic          local_pulse,
    input logic          drop_pulse,
    input logic [7:0]    status,
    input logic [CW-1:0] err_count
);
    localparam logic [CW-1:0] CMAX = '1;

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fwd_pulse, local_pulse, drop_pulse}));

    a_r2_one_per_pkt: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |=> $countones({fwd_pulse, local_pulse, drop_pulse}) == 1);

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> !(fwd_pulse || local_pulse || drop_pulse));

    a_r6_reset_drops: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && bus_reset) |=> (drop_pulse && status[0]));

    a_r7_drop_flagged: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> status[1]);

    a_r8_err_inc: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && (ctrl_word[15:9] != 7'd0) && err_count != CMAX)
        |=> err_count == $past(err_count) + 1'b1);

    a_r9_status_stable: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> ($stable(status) && $stable(err_count)));

    a_r9_zero_bits: assert property (@(posedge clk) disable iff (rst)
        status[7:4] == 4'd0 && !status[2]);
endmodule

bind fwd_gate fgate_chk #(.CW(ERR_CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .pkt_valid   (pkt_valid),
    .ctrl_word   (ctrl_word),
    .bus_reset   (bus_reset),
    .fwd_pulse   (fwd_pulse),
    .local_pulse (local_pulse),
    .drop_pulse  (drop_pulse),
    .status      (status),
    .err_count   (err_count)
);

// File: tb/fwd_gate_tb.sv
module fwd_gate_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_valid;
    logic [15:0] ctrl_word;
    logic        is_bcast;
    logic [7:0]  local_gen;
    logic        bus_reset;
    logic        fwd_pulse, local_pulse, drop_pulse;
    logic [7:0]  status;
    logic [7:0]  err_count;

    int total = 0;
    int bad   = 0;
    int m_cnt = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    fwd_gate dut_i (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .ctrl_word(ctrl_word),
        .is_bcast(is_bcast), .local_gen(local_gen), .bus_reset(bus_reset),
        .fwd_pulse(fwd_pulse), .local_pulse(local_pulse), .drop_pulse(drop_pulse),
        .status(status), .err_count(err_count)
    );

    // expected pulses as {fwd, local, drop}
    function automatic logic [2:0] exp_pulses(input logic [15:0] w, input logic bc,
                                              input logic [7:0] lg, input logic br);
        if (w[15:9] != 0 || br || w[7:0] != lg) return 3'b001;
        if (bc && w[8]) return 3'b010;
        return 3'b100;
    endfunction

    function automatic logic [7:0] exp_status(input logic [15:0] w, input logic bc,
                                              input logic [7:0] lg, input logic br);
        logic [2:0] p;
        p = exp_pulses(w, bc, lg, br);
        return {4'd0, (w[15:9] != 0), 1'b0, p[0], br};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    logic [7:0] last_stat = 8'd0;

    task automatic send(input string req, input logic [15:0] w, input logic bc,
                        input logic [7:0] lg, input logic br);
        pkt_valid = 1'b1; ctrl_word = w; is_bcast = bc; local_gen = lg; bus_reset = br;
        @(negedge clk);
        if (w[15:9] != 0 && m_cnt != 255) m_cnt++;
        last_stat = exp_status(w, bc, lg, br);
        chk(req, {fwd_pulse, local_pulse, drop_pulse}, exp_pulses(w, bc, lg, br));
        chk(req, status, last_stat);
        chk(req, err_count, m_cnt);
        pkt_valid = 1'b0;
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        chk(req, {fwd_pulse, local_pulse, drop_pulse}, 3'b000);
        chk(req, status, last_stat);
        chk(req, err_count, m_cnt);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        rst = 1'b1; pkt_valid = 0; ctrl_word = 0; is_bcast = 0; local_gen = 0; bus_reset = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", {fwd_pulse, local_pulse, drop_pulse, status, err_count}, 19'd0);

        // directed
        send("R3", 16'h0005, 1'b0, 8'h05, 1'b0);
        idle_check("R2");
        send("R4", 16'h0112, 1'b1, 8'h12, 1'b0);
        send("R5", 16'h0112, 1'b0, 8'h12, 1'b0);
        send("R3", 16'h0033, 1'b1, 8'h33, 1'b0);
        send("R6", 16'h0044, 1'b0, 8'h44, 1'b1);
        send("R7", 16'h0044, 1'b0, 8'h45, 1'b0);
        send("R8", 16'h0244, 1'b0, 8'h44, 1'b0);
        send("R8", 16'h8144, 1'b1, 8'h44, 1'b1);
        // R10: change gen and reset away from strobe
        local_gen = 8'h99; bus_reset = 1'b1;
        idle_check("R10");
        bus_reset = 1'b0;
        idle_check("R9");
        send("R7", 16'h0099, 1'b1, 8'h98, 1'b0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w;
            logic [7:0]  lg;
            lg = 8'($urandom);
            w[7:0]  = ($urandom % 4 == 0) ? 8'($urandom) : lg;
            w[8]    = 1'($urandom);
            w[15:9] = ($urandom % 5 == 0) ? 7'($urandom) : 7'd0;
            send("R2", w, 1'($urandom), lg, ($urandom % 6 == 0));
            if ($urandom % 3 == 0) begin
                local_gen = 8'($urandom);
                idle_check("R10");
            end
        end

        // R8 saturation
        for (int i = 0; i < 260; i++) send("R8", 16'hFE00, 1'b0, 8'h00, 1'b0);
        chk("R8", err_count, 8'd255);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule